// File: doc/BRIEF.md
# Interrupt-Aware Low-Power Request Gate

This block sits between a processor core and the chip's power sequencer. Software arms low power by setting a wait-enable bit. The core's requested modes (doze, nap and sleep) reach the sequencer only while that bit is set. Each mode output is the AND of its request and wait-enable.

When the core takes an interrupt, the block copies wait-enable into a save slot for that interrupt class. The classes are normal, critical and machine-check. Wait-enable is then cleared, so every power request drops while the handler runs. On the matching return strobe, wait-enable is reloaded from that class's slot. The requests then come back as they were, and software does not have to re-arm them. Because each class has its own slot, handlers of different classes can nest without losing each other's saved value.

The block has no data streams. All pins are plain single-cycle strobes and levels sampled on the rising clock edge. Class vectors use bit 0 for normal, bit 1 for critical and bit 2 for machine-check.

Top module: `pwr_req_gate`

## Requirements
- R1: Each bit of `mode_out` equals the same bit of `mode_req` ANDed with the wait-enable register, combinationally; bit 0 is doze, bit 1 nap, bit 2 sleep.
- R2: Reset clears wait-enable and all three save slots to 0, so all outputs are low after reset and a return without any entry then yields 0.
- R3: With no entry or return strobe, a cycle with `we_wr_en` high loads `we_wr_data` into wait-enable from the next cycle.
- R4: An entry strobe on bit c of `enter_stb` (0 normal, 1 critical, 2 machine-check) stores the current wait-enable into slot c, and from the next cycle wait-enable is 0 and all outputs are low.
- R5: A return strobe on bit c of `ret_stb`, with no entry in that cycle, reloads wait-enable from slot c, so the outputs resume their pre-interrupt state.
- R6: Nested entries of different classes keep separate copies; a machine-check return inside a critical handler restores the critical handler's value (0), and the later critical return restores the value from before the critical entry.
- R7: When an entry and a software write fall in the same cycle, the entry wins: the slot receives the wait-enable value from before the write, and wait-enable becomes 0.
- R8: A return for a class with no outstanding entry reloads that slot's present contents; return strobes never modify any slot.
- R9: Priority per cycle is entry over return over write. Among simultaneous returns, the highest-numbered class (machine-check, then critical, then normal) supplies the reloaded value.
- R10: An entry of one class leaves the slots of the other classes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_stb | input | 3 | Interrupt-entry strobes, bit 0 normal, 1 critical, 2 machine-check |
| ret_stb | input | 3 | Return-from-interrupt strobes, same bit order |
| we_wr_en | input | 1 | Software write strobe for wait-enable |
| we_wr_data | input | 1 | Value written to wait-enable |
| mode_req | input | 3 | Requested modes: bit 0 doze, 1 nap, 2 sleep |
| mode_out | output | 3 | Gated mode requests to the power sequencer |

## Verification
Entry, return and software-write strobes can all arrive in the same cycle, in any mix of classes. The bench provokes every such mix by sweeping all 256 combinations of the three strobe fields, twice and from different stored states. A reference model built only on the priority rule (entry over return over write, highest return class first) judges the gated outputs. Directed sequences cover nesting across classes, an entry that collides with a write, and returns that have no matching entry.

// File: rtl/pwrg_pkg.sv
package pwrg_pkg;
  localparam int unsigned CLASS_COUNT = 3;
  localparam int unsigned MODE_COUNT  = 3;

  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_CRIT   = 2'd1,
    CLS_MCHK   = 2'd2
  } irq_class_e;

  typedef enum logic [1:0] {
    ACT_ENTER  = 2'd0,
    ACT_RETURN = 2'd1,
    ACT_WRITE  = 2'd2,
    ACT_HOLD   = 2'd3
  } we_action_e;
endpackage

// File: rtl/pwrg_save_slot.sv
module pwrg_save_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic we_in,
  output logic slot_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       slot_q <= 1'b0;
    else if (capture) slot_q <= we_in;
  end

  // R4: a capture stores the wait-enable value seen in that cycle
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> slot_q == $past(we_in));

  // R8: without a capture the slot keeps its value; returns cannot touch it
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(slot_q));
endmodule

// File: rtl/pwrg_we_ctrl.sv
module pwrg_we_ctrl #(
  parameter int unsigned NCLS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] enter_stb,
  input  logic [NCLS-1:0] ret_stb,
  input  logic [NCLS-1:0] slots,
  input  logic            wr_en,
  input  logic            wr_data,
  output logic            we_q
);
  import pwrg_pkg::*;

  logic       enter_any;
  logic       ret_any;
  logic       ret_val;
  we_action_e action;

  assign enter_any = |enter_stb;
  assign ret_any   = |ret_stb;

  // Highest-numbered class among simultaneous returns supplies the value.
  always_comb begin
    ret_val = 1'b0;
    for (int i = 0; i < int'(NCLS); i++) begin
      if (ret_stb[i]) ret_val = slots[i];
    end
  end

  always_comb begin
    if (enter_any)    action = ACT_ENTER;
    else if (ret_any) action = ACT_RETURN;
    else if (wr_en)   action = ACT_WRITE;
    else              action = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) we_q <= 1'b0;
    else begin
      case (action)
        ACT_ENTER:  we_q <= 1'b0;
        ACT_RETURN: we_q <= ret_val;
        ACT_WRITE:  we_q <= wr_data;
        default:    we_q <= we_q;
      endcase
    end
  end

  // R4 / R7: any entry, whatever else happens, clears wait-enable
  p_enter_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_any |=> !we_q);

  // R3: a lone write lands on wait-enable
  p_write_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter_any && !ret_any && wr_en) |=> we_q == $past(wr_data));

  // R9: with no strobe at all, wait-enable holds
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter_any && !ret_any && !wr_en) |=> $stable(we_q));
endmodule

// File: rtl/pwrg_gate.sv
module pwrg_gate #(
  parameter int unsigned NMODE = 3
) (
  input  logic [NMODE-1:0] mode_req,
  input  logic             we,
  output logic [NMODE-1:0] mode_out
);
  for (genvar m = 0; m < int'(NMODE); m++) begin : g_mode
    assign mode_out[m] = mode_req[m] & we;
  end
endmodule

// File: rtl/pwr_req_gate.sv
module pwr_req_gate #(
  parameter int unsigned NCLS  = pwrg_pkg::CLASS_COUNT,
  parameter int unsigned NMODE = pwrg_pkg::MODE_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCLS-1:0]  enter_stb,
  input  logic [NCLS-1:0]  ret_stb,
  input  logic             we_wr_en,
  input  logic             we_wr_data,
  input  logic [NMODE-1:0] mode_req,
  output logic [NMODE-1:0] mode_out
);
  logic            we_q;
  logic [NCLS-1:0] slots;

  for (genvar c = 0; c < int'(NCLS); c++) begin : g_slot
    pwrg_save_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (enter_stb[c]),
      .we_in   (we_q),
      .slot_q  (slots[c])
    );
  end

  pwrg_we_ctrl #(.NCLS(NCLS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_stb (enter_stb),
    .ret_stb   (ret_stb),
    .slots     (slots),
    .wr_en     (we_wr_en),
    .wr_data   (we_wr_data),
    .we_q      (we_q)
  );

  pwrg_gate #(.NMODE(NMODE)) u_gate (
    .mode_req (mode_req),
    .we       (we_q),
    .mode_out (mode_out)
  );

  // R4: outputs are low in the cycle after any interrupt entry
  p_out_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|enter_stb) |=> mode_out == '0);

  // R2: outputs are low in the first cycle out of reset
  p_reset_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> mode_out == '0);

  // R1: an output never rises without its request
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out & ~mode_req) == '0);

  // R10: an entry of class 0 alone leaves class 2's slot untouched
  p_other_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enter_stb[NCLS-1] |=> $stable(slots[NCLS-1]));
endmodule

// File: tb/test_pwr_req_gate.sv
module test_pwr_req_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] enter_stb = '0;
  logic [2:0] ret_stb = '0;
  logic       we_wr_en = 1'b0;
  logic       we_wr_data = 1'b0;
  logic [2:0] mode_req = '0;
  logic [2:0] mode_out;

  int n_chk = 0;
  int n_bad = 0;
  logic       m_we;
  logic [2:0] m_slot;

  always #4 clk = ~clk;

  pwr_req_gate i_pwr_req_gate (
    .clk(clk), .rst_n(rst_n), .enter_stb(enter_stb), .ret_stb(ret_stb),
    .we_wr_en(we_wr_en), .we_wr_data(we_wr_data), .mode_req(mode_req),
    .mode_out(mode_out)
  );

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s mode_out=%b expected=%b", tag, got, exp);
    end
  endtask

  // Drives one cycle of stimulus at the falling edge, checks the gated
  // output against the model, then advances the model across the edge.
  task automatic step(input string tag, input logic [2:0] en, input logic [2:0] rt,
                      input logic wen, input logic wd, input logic [2:0] req);
    enter_stb = en; ret_stb = rt; we_wr_en = wen; we_wr_data = wd; mode_req = req;
    #1;
    check(tag, mode_out, req & {3{m_we}});
    @(posedge clk);
    if (|en) begin
      for (int c = 0; c < 3; c++) if (en[c]) m_slot[c] = m_we;
      m_we = 1'b0;
    end else if (|rt) begin
      for (int c = 0; c < 3; c++) if (rt[c]) m_we = m_slot[c];
    end else if (wen) m_we = wd;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(tag, 3'b000, 3'b000, 1'b0, 1'b0, 3'b111);
  endtask

  initial begin
    m_we = 1'b0; m_slot = '0;
    mode_req = 3'b111;
    repeat (3) @(negedge clk);
    #1 check("R2", mode_out, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 / R8: return with nothing outstanding after reset gives 0
    step("R2", 3'b000, 3'b001, 1'b0, 1'b0, 3'b111);
    idle("R8");
    // R3 write, then R1 with several request patterns
    step("R3", 3'b000, 3'b000, 1'b1, 1'b1, 3'b101);
    step("R1", 3'b000, 3'b000, 1'b0, 1'b0, 3'b010);
    step("R1", 3'b000, 3'b000, 1'b0, 1'b0, 3'b100);
    // R4 critical entry, R6 nested machine check, R5 returns
    step("R4", 3'b010, 3'b000, 1'b0, 1'b0, 3'b111);
    step("R4", 3'b100, 3'b000, 1'b0, 1'b0, 3'b111);
    step("R6", 3'b000, 3'b100, 1'b0, 1'b0, 3'b111);
    step("R6", 3'b000, 3'b010, 1'b0, 1'b0, 3'b111);
    idle("R5");
    // R7: entry collides with write 0; slot keeps pre-write 1
    step("R7", 3'b001, 3'b000, 1'b1, 1'b0, 3'b111);
    step("R7", 3'b000, 3'b001, 1'b0, 1'b0, 3'b111);
    idle("R7");
    // R8: repeated return, and return after a write of 0
    step("R8", 3'b000, 3'b001, 1'b0, 1'b0, 3'b111);
    step("R8", 3'b000, 3'b000, 1'b1, 1'b0, 3'b111);
    step("R8", 3'b000, 3'b001, 1'b0, 1'b0, 3'b111);
    idle("R8");
    // R10: normal entry leaves machine-check slot (0) intact
    step("R10", 3'b001, 3'b000, 1'b0, 1'b0, 3'b111);
    step("R10", 3'b000, 3'b100, 1'b0, 1'b0, 3'b111);
    step("R10", 3'b000, 3'b001, 1'b0, 1'b0, 3'b111);
    idle("R10");
    // R9: sweep of all strobe combinations, two passes
    for (int pass = 0; pass < 2; pass++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] s;
        string t;
        s = 8'(v) ^ 8'(pass * 8'h5a);
        if (s[2:0] != 0)      t = "R9";
        else if (s[5:3] != 0) t = "R5";
        else if (s[6])        t = "R3";
        else                  t = "R1";
        step(t, s[2:0], s[5:3], s[6], s[7], 3'(v + pass));
      end
    end
    idle("R9");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule